// File: doc/BRIEF.md
# Committed Address Window Decoder

This block decides whether a memory address falls inside one programmable window. Software programs a base and a size through a small register port. Those registers never drive the decode directly. Raising the commit control bit starts a short validation sequence. If the checks pass, the sequence copies base and size into a hidden snapshot, and the lookup port then compares against that snapshot only.

The committed status bit drops as soon as commit rises. It comes back only when the sequence finishes with a valid configuration. If the configuration is rejected, the error bit is raised instead. Once committed, the block ignores later edits to the programming registers. Lowering commit changes nothing. The only way to retire or replace a window is a fresh rising edge of commit. A lock option makes base and size read-only while the sequence runs and while a window is committed.

Top module: `addr_window_commit`

## Requirements
- R1: Register select codes are 0 = base, 1 = size, 2 = control. Base and size read back as written. In the control word, bit 0 is commit and bit 1 is lock, both written by software; bit 2 is committed and bit 3 is error, both read-only.
- R2: A control write that takes commit from 0 to 1 clears committed and error on the same clock edge. From that edge on, every lookup misses until the sequence ends.
- R3: With a valid configuration, committed reads 1 exactly COMMIT_CYCLES clock edges after the edge that accepted the commit write, and reads 0 before that.
- R4: After a successful commit, a lookup address A hits exactly when snapshot base <= A < snapshot base + snapshot size.
- R5: Writes to base or size after a successful commit leave lookup results unchanged. The new values take effect only after the next 0-to-1 commit sequence.
- R6: If size is zero, or base has any of its low GRAN_BITS bits set (default 28, a 256 MB granule), the sequence ends with error = 1 and committed = 0, and every lookup misses.
- R7: Writing commit = 0, or writing commit = 1 while it is already 1, leaves committed, error and the lookup results unchanged.
- R8: While lock is 1 and either a sequence is running or a window is committed, writes to base and size are dropped. Once lock is 0, such writes are accepted again.
- R9: Reset clears all four control bits and both registers, and invalidates the snapshot. Before the first successful commit, every lookup misses.
- R10: The snapshot holds the base and size that were in force just before the final edge of the sequence. A write accepted on that final edge is not captured. A write accepted one edge earlier is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | ADDR_W | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | ADDR_W | Read data (combinational) |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup address lies inside the committed window |

## Verification
Two things can land on the same clock edge: a software write to base and the commit sequence capturing its snapshot. The bench aims a base write exactly at the final edge of a sequence. It then aims a second write one edge earlier in a later sequence. After the first case, the old window must still hit and the new address must miss. After the second, the newly written base must hit. This pins down which edge the capture samples.

// File: rtl/win_pkg.sv
package win_pkg;
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_CTRL = 2'd2
    } win_sel_e;

    localparam int CTL_COMMIT = 0;
    localparam int CTL_LOCK   = 1;
    localparam int CTL_DONE   = 2;
    localparam int CTL_ERR    = 3;
endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              lock_block,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] size_o,
    output logic              commit_o,
    output logic              lock_o,
    output logic              start_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic              commit;
        logic              lock;
    } regs_t;

    regs_t q, d;
    logic  bs_open;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        bs_open = !(q.lock && lock_block);
        if (wr_en) begin
            case (wr_sel)
                SEL_BASE: if (bs_open) d.base = wr_data;
                SEL_SIZE: if (bs_open) d.size = wr_data;
                SEL_CTRL: begin
                    d.commit = wr_data[CTL_COMMIT];
                    d.lock   = wr_data[CTL_LOCK];
                    start_o  = wr_data[CTL_COMMIT] && !q.commit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base_o   = q.base;
    assign size_o   = q.size;
    assign commit_o = q.commit;
    assign lock_o   = q.lock;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock && lock_block) |=> ($stable(q.base) && $stable(q.size))); // R8
endmodule

// File: rtl/win_commit.sv
module win_commit #(
    parameter int ADDR_W        = 40,
    parameter int GRAN_BITS     = 28,
    parameter int COMMIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] sbase_o,
    output logic [ADDR_W-1:0] ssize_o
);
    localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              err;
        logic              valid;
        logic [ADDR_W-1:0] sbase;
        logic [ADDR_W-1:0] ssize;
    } seq_t;

    seq_t q, d;
    logic finish, cfg_ok;

    always_comb begin
        d      = q;
        finish = q.busy && (q.cnt == LAST);
        cfg_ok = (size_i != '0) && (base_i[GRAN_BITS-1:0] == '0);
        if (start) begin
            d.busy  = 1'b1;
            d.cnt   = '0;
            d.done  = 1'b0;
            d.err   = 1'b0;
            d.valid = 1'b0;
        end else if (q.busy) begin
            if (finish) begin
                d.busy = 1'b0;
                if (cfg_ok) begin
                    d.done  = 1'b1;
                    d.valid = 1'b1;
                    d.sbase = base_i;
                    d.ssize = size_i;
                end else begin
                    d.err = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o  = q.busy;
    assign done_o  = q.done;
    assign err_o   = q.err;
    assign valid_o = q.valid;
    assign sbase_o = q.sbase;
    assign ssize_o = q.ssize;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!q.done && !q.err)); // R2
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !q.done); // R3
    AST_ERR_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> !q.valid); // R6
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !q.busy) |=> ($stable(q.sbase) && $stable(q.ssize) && $stable(q.valid))); // R5
endmodule

// File: rtl/win_match.sv
module win_match #(
    parameter int ADDR_W = 40
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] sbase,
    input  logic [ADDR_W-1:0] ssize,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W:0] limit;

    always_comb begin
        limit = {1'b0, sbase} + {1'b0, ssize};
        hit   = valid && (addr >= sbase) && ({1'b0, addr} < limit);
    end
endmodule

// File: rtl/addr_window_commit.sv
module addr_window_commit
    import win_pkg::*;
#(
    parameter int ADDR_W        = 40,
    parameter int GRAN_BITS     = 28,
    parameter int COMMIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [ADDR_W-1:0] reg_rd_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit
);
    logic [ADDR_W-1:0] base_q, size_q, sbase, ssize;
    logic commit_q, lock_q, start;
    logic busy, done, err, valid;

    win_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .lock_block(busy || done),
        .base_o(base_q), .size_o(size_q),
        .commit_o(commit_q), .lock_o(lock_q), .start_o(start)
    );

    win_commit #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_i(base_q), .size_i(size_q),
        .busy_o(busy), .done_o(done), .err_o(err), .valid_o(valid),
        .sbase_o(sbase), .ssize_o(ssize)
    );

    win_match #(.ADDR_W(ADDR_W)) u_match (
        .valid(valid), .sbase(sbase), .ssize(ssize),
        .addr(lk_addr), .hit(lk_hit)
    );

    always_comb begin
        case (reg_rd_sel)
            SEL_BASE: reg_rd_data = base_q;
            SEL_SIZE: reg_rd_data = size_q;
            SEL_CTRL: begin
                reg_rd_data             = '0;
                reg_rd_data[CTL_COMMIT] = commit_q;
                reg_rd_data[CTL_LOCK]   = lock_q;
                reg_rd_data[CTL_DONE]   = done;
                reg_rd_data[CTL_ERR]    = err;
            end
            default:  reg_rd_data = '0;
        endcase
    end

    AST_MISS_UNCOMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !lk_hit); // R9
    AST_FALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel == SEL_CTRL && !reg_wr_data[CTL_COMMIT]) |=> $stable(done)); // R7
endmodule

// File: tb/sim_addr_window_commit.sv
`timescale 1ns/1ps
module sim_addr_window_commit;
    localparam int AW = 40;
    localparam logic [AW-1:0] SZ = 40'h00_1000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
    logic [AW-1:0] wr_data = '0, rd_data, lk_addr = '0;
    logic lk_hit;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    addr_window_commit u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(wr_en), .reg_wr_sel(wr_sel), .reg_wr_data(wr_data),
        .reg_rd_sel(rd_sel), .reg_rd_data(rd_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [AW-1:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic look(input string req, input logic [AW-1:0] a, input logic exp);
        lk_addr = a; #1;
        chk(req, 64'(lk_hit), 64'(exp));
    endtask

    task automatic ctl_bit(input string req, input int bitn, input logic exp);
        logic [AW-1:0] v;
        rd(2'd2, v);
        chk(req, 64'(v[bitn]), 64'(exp));
    endtask

    task automatic t_reset;
        logic [AW-1:0] v;
        rd(2'd2, v); chk("R9 ctrl after reset", 64'(v), 64'h0);
        rd(2'd0, v); chk("R9 base after reset", 64'(v), 64'h0);
        look("R9 miss after reset", '0, 1'b0);
    endtask

    task automatic t_readback;
        logic [AW-1:0] v;
        wr(2'd0, 40'h01_0000_0000);
        wr(2'd1, SZ);
        rd(2'd0, v); chk("R1 base readback", 64'(v), 64'h01_0000_0000);
        rd(2'd1, v); chk("R1 size readback", 64'(v), 64'(SZ));
        look("R9 miss before first commit", 40'h01_0000_0000, 1'b0);
    endtask

    task automatic t_commit;
        logic [AW-1:0] v;
        wr(2'd2, 40'h1);
        ctl_bit("R2 committed low after start", 2, 1'b0);
        repeat (3) @(negedge clk);
        ctl_bit("R3 committed still low at edge 3", 2, 1'b0);
        @(negedge clk);
        ctl_bit("R3 committed high at edge 4", 2, 1'b1);
        rd(2'd2, v); chk("R1 ctrl word", 64'(v), 64'h5);
        look("R4 hit at base", 40'h01_0000_0000, 1'b1);
        look("R4 hit at last byte", 40'h01_0FFF_FFFF, 1'b1);
        look("R4 miss at end", 40'h01_1000_0000, 1'b0);
        look("R4 miss below base", 40'h00_FFFF_FFFF, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_edits;
        wr(2'd0, 40'h02_0000_0000);
        look("R5 old window still hits", 40'h01_0000_0000, 1'b1);
        look("R5 new base not used", 40'h02_0000_0000, 1'b0);
        @(negedge clk);
        wr(2'd2, 40'h1);
        ctl_bit("R7 repeated commit=1 keeps committed", 2, 1'b1);
        wr(2'd2, 40'h0);
        ctl_bit("R7 commit=0 keeps committed", 2, 1'b1);
        look("R7 commit=0 keeps decode", 40'h01_0000_0000, 1'b1);
        @(negedge clk);
        wr(2'd2, 40'h1);
        look("R2 miss during sequence", 40'h01_0000_0000, 1'b0);
        repeat (4) @(negedge clk);
        look("R5 new base active after recommit", 40'h02_0000_0000, 1'b1);
        look("R5 old base retired", 40'h01_0000_0000, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_error;
        wr(2'd2, 40'h0);
        wr(2'd1, 40'h0);
        wr(2'd2, 40'h1);
        repeat (4) @(negedge clk);
        ctl_bit("R6 zero size sets error", 3, 1'b1);
        ctl_bit("R6 zero size not committed", 2, 1'b0);
        look("R6 miss after failed commit", 40'h02_0000_0000, 1'b0);
        @(negedge clk);
        wr(2'd2, 40'h0);
        ctl_bit("R7 commit=0 keeps error", 3, 1'b1);
        wr(2'd1, SZ);
        wr(2'd0, 40'h02_0000_1000);
        wr(2'd2, 40'h1);
        ctl_bit("R2 start clears error", 3, 1'b0);
        repeat (4) @(negedge clk);
        ctl_bit("R6 misaligned base sets error", 3, 1'b1);
        look("R6 miss with misaligned base", 40'h02_0000_1000, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_lock;
        logic [AW-1:0] v;
        wr(2'd2, 40'h0);
        wr(2'd0, 40'h03_0000_0000);
        wr(2'd2, 40'h3);
        wr(2'd0, 40'h04_0000_0000);
        rd(2'd0, v); chk("R8 base locked while busy", 64'(v), 64'h03_0000_0000);
        repeat (4) @(negedge clk);
        ctl_bit("R3 committed with lock", 2, 1'b1);
        wr(2'd1, 40'h00_2000_0000);
        rd(2'd1, v); chk("R8 size locked while committed", 64'(v), 64'(SZ));
        wr(2'd2, 40'h0);
        wr(2'd0, 40'h04_0000_0000);
        rd(2'd0, v); chk("R8 base writable after unlock", 64'(v), 64'h04_0000_0000);
        look("R5 decode keeps locked snapshot", 40'h03_0000_0000, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_race;
        wr(2'd2, 40'h0);
        wr(2'd0, 40'h05_0000_0000);
        wr(2'd2, 40'h1);
        repeat (3) @(negedge clk);
        wr(2'd0, 40'h06_0000_0000);
        ctl_bit("R10 committed at final edge", 2, 1'b1);
        look("R10 final-edge write not captured", 40'h05_0000_0000, 1'b1);
        look("R10 final-edge value unused", 40'h06_0000_0000, 1'b0);
        @(negedge clk);
        wr(2'd2, 40'h0);
        wr(2'd2, 40'h1);
        repeat (2) @(negedge clk);
        wr(2'd0, 40'h07_0000_0000);
        @(negedge clk);
        ctl_bit("R10 committed after second run", 2, 1'b1);
        look("R10 earlier-edge write captured", 40'h07_0000_0000, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_readback();
        t_commit();
        t_edits();
        t_error();
        t_lock();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule